// File: doc/BRIEF.md
# Restart Acknowledge Bus Sequencer

This block carries out the bus activity that follows the acceptance of an interrupt or a restart on an 8-bit processor with a 16-bit address space. A one-cycle start pulse launches a fixed three-phase sequence. Each clock cycle is one T-state.

The first phase lasts six T-states. During this phase the acknowledge strobe is driven and the interrupting device places a restart opcode on the data input. The block accepts only the form `11nnn111` for this opcode. The second phase lasts three T-states and pushes the high byte of the return address. The third phase also lasts three T-states and pushes the low byte. The block then reports the restart vector and the lowered stack pointer for one cycle.

The return address is the program counter value given at start, which is the address of the next instruction. The caller updates its own PC and SP from the outputs when `done_o` is seen. If the sampled opcode is not a restart, no write takes place and an error pulse is given instead.

Top module: `restart_ack_sequencer`

## Requirements
- R1: While reset is held and after its release, `inta_o`, `wr_o`, `done_o` and `err_o` are low, and `addr_o`, `dout_o`, `pc_o` and `sp_o` are zero.
- R2: A `start_i` pulse sampled while the block is idle raises `inta_o` for exactly six consecutive cycles, beginning the cycle after the start edge. During those cycles `addr_o` carries the captured PC and `wr_o` stays low.
- R3: The opcode is taken from `din_i` at the clock edge that ends the sixth acknowledge cycle. It is a valid restart only when bits 7:6 are `11` and bits 2:0 are `111`. The restart number n is bits 5:3.
- R4: After a valid opcode, the next three cycles drive `addr_o` = SP-1 and `dout_o` = PC[15:8]. `wr_o` is high only in the second of these three cycles.
- R5: The three cycles after R4 drive `addr_o` = SP-2 and `dout_o` = PC[7:0]. `wr_o` is high only in the second of these three cycles.
- R6: In the cycle after the last push cycle, `done_o` is high for exactly one cycle. In that cycle `pc_o` = n×8 (range 0x0000 to 0x0038) and `sp_o` = SP-2. Both outputs then hold their values until the next sequence completes.
- R7: PC and SP are captured at the start edge. Changes on `pc_i` and `sp_i` later in the sequence have no effect on the addresses, the data or the results.
- R8: An invalid opcode gives a single-cycle `err_o` in the cycle right after the acknowledge phase, with `pc_o` = captured PC and `sp_o` = captured SP. In that case there is no write, no `done_o`, and the block returns to idle in the next cycle.
- R9: A `start_i` pulse that arrives while a sequence is in progress, including its final result cycle, is ignored.
- R10: Stack addresses wrap modulo 2^16 (for example, SP = 0x0001 gives push addresses 0x0000 and 0xFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins a sequence when idle |
| pc_i | input | 16 | Address of the next instruction |
| sp_i | input | 16 | Current stack pointer |
| din_i | input | 8 | Data bus input carrying the restart opcode |
| addr_o | output | 16 | Address bus |
| dout_o | output | 8 | Data bus output for stack writes |
| wr_o | output | 1 | Memory write strobe |
| inta_o | output | 1 | Interrupt acknowledge strobe |
| pc_o | output | 16 | Restart vector, or captured PC after an error |
| sp_o | output | 16 | Lowered stack pointer, or captured SP after an error |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a non-restart opcode |

## Verification
The hardest situations to reach are those where the inputs move while a sequence is already running. These include a second start pulse during the pushes or in the final result cycle, and PC or SP changing after capture. A wrong design here would quietly reload its state. In a subset of the random sequences, the bench therefore rewrites `pc_i` and `sp_i` and pulses `start_i` in the middle of the sequence and again in the result cycle. It then confirms that the addresses, the data, the results and the return to idle all follow the values captured at start. Stack pointers near zero and the full range of opcodes (valid and invalid) are mixed in by directed cases.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ACK  = 3'd1,
    PH_HI   = 3'd2,
    PH_LO   = 3'd3,
    PH_FIN  = 3'd4
  } phase_e;
endpackage

// File: rtl/rsq_tstate.sv
// T-state counter: counts within a phase and wraps when the phase's last index is reached.
module rsq_tstate #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] last_idx,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] cnt_d;

  assign last = run && (cnt == last_idx);

  always_comb begin
    cnt_d = cnt;
    if (!run || last) cnt_d = '0;
    else              cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // Counter must never run past the index of the phase's last T-state (R2, R4, R5)
  assert_cnt_in_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last_idx));
endmodule

// File: rtl/rsq_opdec.sv
// Restart opcode recognizer and vector generator.
module rsq_opdec #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic [DW-1:0] op,
  output logic          valid,
  output logic [AW-1:0] vector
);
  localparam int NW = 3;
  logic [NW-1:0] num;

  assign num = op[5:3];

  always_comb begin
    valid  = (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
    vector = '0;
    vector[NW+2:3] = num;
  end

  // Vector is always 8-byte aligned and inside the restart window (R6)
  always_comb begin
    assert_vec_aligned_R6: assert (vector[2:0] == 3'b000 && vector <= AW'(56));
  end
endmodule

// File: rtl/rsq_bus.sv
// Bus output mux driven by the current phase and T-state.
module rsq_bus #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CW    = 3,
  parameter int WR_AT = 1
) (
  input  rsq_pkg::phase_e phase,
  input  logic [CW-1:0]   cnt,
  input  logic [AW-1:0]   pc_q,
  input  logic [AW-1:0]   sp_q,
  output logic [AW-1:0]   addr,
  output logic [DW-1:0]   dout,
  output logic            wr,
  output logic            inta
);
  import rsq_pkg::*;
  localparam logic [CW-1:0] WR_IDX = CW'(WR_AT);

  always_comb begin
    addr = '0;
    dout = '0;
    wr   = 1'b0;
    inta = 1'b0;
    unique case (phase)
      PH_ACK: begin
        addr = pc_q;
        inta = 1'b1;
      end
      PH_HI: begin
        addr = sp_q - AW'(1);
        dout = pc_q[AW-1:AW-DW];
        wr   = (cnt == WR_IDX);
      end
      PH_LO: begin
        addr = sp_q - AW'(2);
        dout = pc_q[DW-1:0];
        wr   = (cnt == WR_IDX);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/restart_ack_sequencer.sv
module restart_ack_sequencer #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int ACK_T  = 6,
  parameter int PUSH_T = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] din_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dout_o,
  output logic          wr_o,
  output logic          inta_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic          done_o,
  output logic          err_o
);
  import rsq_pkg::*;

  localparam int TMAX = (ACK_T > PUSH_T) ? ACK_T : PUSH_T;
  localparam int CW   = (TMAX > 2) ? $clog2(TMAX) : 1;
  localparam logic [CW-1:0] ACK_LAST  = CW'(ACK_T - 1);
  localparam logic [CW-1:0] PUSH_LAST = CW'(PUSH_T - 1);

  phase_e        phase_q, phase_d;
  logic [AW-1:0] pc_q, sp_q, vec_q;
  logic          bad_q;
  logic [AW-1:0] pc_res_q, sp_res_q;
  logic [AW-1:0] pc_res_d, sp_res_d;
  logic [CW-1:0] cnt, last_idx;
  logic          run, last;
  logic          cap_en, op_en, res_en;
  logic          op_valid;
  logic [AW-1:0] op_vector;

  assign run      = (phase_q == PH_ACK) || (phase_q == PH_HI) || (phase_q == PH_LO);
  assign last_idx = (phase_q == PH_ACK) ? ACK_LAST : PUSH_LAST;

  rsq_tstate #(.CW(CW)) u_tstate (
    .clk(clk), .rst_n(rst_n), .run(run), .last_idx(last_idx), .cnt(cnt), .last(last)
  );

  rsq_opdec #(.DW(DW), .AW(AW)) u_opdec (
    .op(din_i), .valid(op_valid), .vector(op_vector)
  );

  rsq_bus #(.AW(AW), .DW(DW), .CW(CW), .WR_AT(1)) u_bus (
    .phase(phase_q), .cnt(cnt), .pc_q(pc_q), .sp_q(sp_q),
    .addr(addr_o), .dout(dout_o), .wr(wr_o), .inta(inta_o)
  );

  // Next phase
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_ACK;
      PH_ACK:  if (last) phase_d = op_valid ? PH_HI : PH_FIN;
      PH_HI:   if (last) phase_d = PH_LO;
      PH_LO:   if (last) phase_d = PH_FIN;
      PH_FIN:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // Enables and result values
  always_comb begin
    cap_en   = (phase_q == PH_IDLE) && start_i;
    op_en    = (phase_q == PH_ACK) && last;
    res_en   = (op_en && !op_valid) || ((phase_q == PH_LO) && last);
    pc_res_d = (phase_q == PH_LO) ? vec_q : pc_q;
    sp_res_d = (phase_q == PH_LO) ? (sp_q - AW'(2)) : sp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
    end else if (cap_en) begin
      pc_q <= pc_i;
      sp_q <= sp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      bad_q <= 1'b0;
    end else if (op_en) begin
      vec_q <= op_vector;
      bad_q <= !op_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_res_q <= '0;
      sp_res_q <= '0;
    end else if (res_en) begin
      pc_res_q <= pc_res_d;
      sp_res_q <= sp_res_d;
    end
  end

  assign pc_o   = pc_res_q;
  assign sp_o   = sp_res_q;
  assign done_o = (phase_q == PH_FIN) && !bad_q;
  assign err_o  = (phase_q == PH_FIN) && bad_q;

  // Writes and acknowledge never overlap (R4, R5)
  assert_wr_not_inta_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> !inta_o);
  // Every write targets one of the two stack slots below the captured SP (R10)
  assert_wr_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> ((addr_o == sp_q - AW'(1)) || (addr_o == sp_q - AW'(2))));
  // Completion and error are exclusive (R8)
  assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  // Results move only in a completion or error cycle (R6)
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_o) |-> (done_o || err_o));
  // A completion pulse lasts one cycle and is followed by idle bus (R6)
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !inta_o && !wr_o));
  // After an error the bus returns idle with no write (R8)
  assert_err_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!wr_o && !inta_o));
endmodule

// File: tb/sim_restart_ack_sequencer.sv
`timescale 1ns/1ps
module sim_restart_ack_sequencer;
  logic        clk, rst_n, start_i;
  logic [15:0] pc_i, sp_i;
  logic [7:0]  din_i;
  logic [15:0] addr_o, pc_o, sp_o;
  logic [7:0]  dout_o;
  logic        wr_o, inta_o, done_o, err_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  restart_ack_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i), .sp_i(sp_i),
    .din_i(din_i), .addr_o(addr_o), .dout_o(dout_o), .wr_o(wr_o), .inta_o(inta_o),
    .pc_o(pc_o), .sp_o(sp_o), .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_rst(input logic [7:0] op);
    return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
  endfunction

  function automatic logic [15:0] vec_of(input logic [7:0] op);
    return {10'd0, op[5:3], 3'b000};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // One full sequence; sample at negedges, j counts cycles after the start edge
  task automatic run_seq(input logic [15:0] pc, input logic [15:0] sp,
                         input logic [7:0] op, input bit disturb);
    logic [15:0] exp_a;
    bit ok;
    ok = is_rst(op);
    pc_i = pc; sp_i = sp; din_i = op; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 1; j <= 13; j++) begin
      if (j <= 6) begin
        chk(inta_o == 1'b1, "R2", "inta in ack", inta_o, 1);
        chk(addr_o == pc, "R2", "addr in ack", addr_o, pc);
        chk(wr_o == 1'b0, "R2", "wr in ack", wr_o, 0);
      end else if (!ok) begin
        chk(err_o == 1'b1, "R8", "err pulse", err_o, 1);
        chk(done_o == 1'b0, "R8", "no done", done_o, 0);
        chk(wr_o == 1'b0 && inta_o == 1'b0, "R8", "bus idle", {wr_o, inta_o}, 0);
        chk(pc_o == pc, "R8", "pc_o", pc_o, pc);
        chk(sp_o == sp, "R8", "sp_o", sp_o, sp);
        if (disturb) start_i = 1'b1;   // R9: start in the result cycle
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o == 1'b0 && inta_o == 1'b0, "R9", "idle after err", {err_o, inta_o}, 0);
        chk(pc_o == pc && sp_o == sp, "R8", "result hold", pc_o, pc);
        return;
      end else if (j <= 12) begin
        exp_a = (j <= 9) ? sp - 16'd1 : sp - 16'd2;
        chk(addr_o == exp_a, (j <= 9) ? "R4" : "R5", "push addr", addr_o, exp_a);
        chk(dout_o == ((j <= 9) ? pc[15:8] : pc[7:0]), (j <= 9) ? "R4" : "R5",
            "push data", dout_o, (j <= 9) ? pc[15:8] : pc[7:0]);
        chk(wr_o == (j == 8 || j == 11), "R4", "wr timing", wr_o, (j == 8 || j == 11));
        chk(inta_o == 1'b0 && done_o == 1'b0, "R5", "no inta/done", {inta_o, done_o}, 0);
      end else begin
        chk(done_o == 1'b1 && err_o == 1'b0, "R6", "done pulse", {done_o, err_o}, 2);
        chk(pc_o == vec_of(op), "R6", "vector", pc_o, vec_of(op));
        chk(sp_o == sp - 16'd2, "R10", "sp result", sp_o, sp - 16'd2);
        if (disturb) start_i = 1'b1;   // R9: start in the result cycle
      end
      if (disturb && j == 3) begin     // R7/R9: inputs move mid-sequence
        pc_i = 16'($urandom); sp_i = 16'($urandom); start_i = 1'b1;
      end
      if (j == 4) start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(done_o == 1'b0 && inta_o == 1'b0 && wr_o == 1'b0, "R9", "idle after done",
        {done_o, inta_o, wr_o}, 0);
    chk(pc_o == vec_of(op) && sp_o == sp - 16'd2, "R7", "result hold", pc_o, vec_of(op));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0]  op;
    logic [15:0] sp;
    void'($urandom(32'd5821));
    rst_n = 1'b0; start_i = 1'b0; pc_i = 16'h1234; sp_i = 16'h8000; din_i = 8'hFF;
    repeat (3) @(negedge clk);
    chk({inta_o, wr_o, done_o, err_o} == 4'b0, "R1", "strobes in reset",
        {inta_o, wr_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_o == 0 && dout_o == 0 && pc_o == 0 && sp_o == 0, "R1", "outputs after reset",
        {addr_o, dout_o}, 0);
    chk({inta_o, wr_o, done_o, err_o} == 4'b0, "R1", "strobes after reset",
        {inta_o, wr_o, done_o, err_o}, 0);
    // Directed corners
    run_seq(16'hABCD, 16'h0001, 8'hC7, 1'b0);   // R10 wrap, RST0
    run_seq(16'h00FF, 16'h0000, 8'hFF, 1'b1);   // R10 wrap, RST7, R9
    run_seq(16'h5A5A, 16'h2000, 8'hC6, 1'b0);   // R3 bit0 clear -> R8
    run_seq(16'h5A5A, 16'h2000, 8'h87, 1'b1);   // R3 bit6 clear -> R8
    run_seq(16'h0102, 16'hFFFF, 8'hEF, 1'b1);   // R7 with RST5
    for (int i = 0; i < 300; i++) begin
      op = 8'($urandom);
      if ($urandom % 3 != 0) op = {2'b11, op[5:3], 3'b111};
      sp = ($urandom % 5 == 0) ? 16'($urandom % 3) : 16'($urandom);
      run_seq(16'($urandom), sp, op, ($urandom % 2) == 1);
      repeat ($urandom % 3) @(negedge clk);
    end
    finish_run();
  end
endmodule